// File: doc/BRIEF.md
# Capacitor Mismatch Calibration Sequencer

This block runs once after power-up, or whenever it is started again, to measure the static error of every capacitor in the most significant section of a differential charge-redistribution converter array. Each side of the array has eight such capacitors: the six binary bits b1 to b6 and the two redundancy capacitors that sit at the b6 level (called here "up" and "down"). The sequencer does not touch analog circuits itself. It asks an external conversion engine to sample one capacitor on one side, then to convert starting at a chosen bit. It then turns the returned code into a signed error value.

The sequencer runs four passes. A mismatch pass covers the P side, then the N side. After each side's mismatch pass, the errors of the five lower bits are corrected by adding the errors of the capacitors above them. An offset pass then runs on the P side, then the N side. It measures the hold-switch charge-injection offset of each capacitor and removes it from that capacitor's error. The results are held in a register file that can be read at any time. A done flag marks the values as complete.

Top module: `capcal_seq`

## Requirements
- R1: After reset, `done_o`, `busy_o` and `cv_req_o` are low, and all 32 register-file entries read as zero.
- R2: Requests follow a fixed order. First the mismatch pass (`cv_mode_o`=0) runs on P (`cv_side_o`=0), then on N. Then the offset pass (`cv_mode_o`=1) runs on P, then on N. Within each side the capacitor index on `cv_cap_o` goes 7, 6, 5, 4, 3, 2, 1, 0. The encoding is: index 0..5 = b1..b6, 6 = b6 up, 7 = b6 down.
- R3: `cv_start_bit_o` is 7 for indexes 5, 6 and 7. For index i from 0 to 4 (bit b(i+1)) it is i+2.
- R4: Values are in half-LSB units. The ideal code is 512 for indexes 5 to 7, and 2^(14-i) for index i from 0 to 4. The raw error is the returned code minus the ideal code.
- R5: For the three b6-level capacitors, the stored error is the raw error minus that capacitor's offset. No compensation is added.
- R6: On the P side, the compensated error of b5 (index 4) is raw b5 + raw b6 + raw b6-down. Each lower index i adds the compensated error of index i+1 to its own raw value. The stored value is then reduced by that capacitor's offset.
- R7: The N side follows the same rule as R6, but uses raw b6-up in place of b6-down.
- R8: In the offset pass, the returned code minus the ideal code is stored in the offset set. The same value is subtracted from that capacitor's error entry.
- R9: While `cv_req_o` is high and `cv_ack_i` is low, the side, capacitor, mode and start bit stay unchanged.
- R10: `done_o` rises in the cycle after the last offset acknowledge, and `busy_o` falls at the same time. A `start_i` pulse while busy is ignored.
- R11: A new `start_i` after completion clears `done_o` at the next edge. It then recomputes every entry from the new measurements.
- R12: Raw errors of ±522 half-LSB (±261 LSB), and sums of such errors, are stored exactly without wrap-around.
- R13: Between start and done, the sequencer leaves `cv_req_o` low for exactly 10 cycles (5 compensation cycles per side). Otherwise it issues the next request in the same cycle as the previous acknowledge.
- R14: Read address bit 4 selects the set (0 = errors, 1 = offsets), bit 3 selects the side, and bits 2..0 select the capacitor index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Pulse that begins a calibration |
| busy_o | output | 1 | Calibration in progress |
| done_o | output | 1 | Register file holds a complete result |
| cv_req_o | output | 1 | Conversion request to the engine |
| cv_side_o | output | 1 | Array side to sample (0 = P, 1 = N) |
| cv_cap_o | output | 3 | Capacitor index to sample |
| cv_mode_o | output | 1 | 0 = mismatch measurement, 1 = hold-offset measurement |
| cv_start_bit_o | output | 4 | Bit position where the conversion begins |
| cv_ack_i | input | 1 | One-cycle acknowledge carrying a valid code |
| cv_code_i | input | 16 | Returned code in half-LSB units |
| rd_addr_i | input | 5 | Register-file read address |
| rd_data_o | output | 16 | Signed read data, half-LSB units |

## Verification
A wrong capacitor counter or side bit shows up at the request port at once. The order of requests goes wrong on the very next request after the fault. A fault in compensation or offset subtraction shows nothing at the request port. It appears only in the register file once `done_o` rises. The bench therefore reads all 32 entries after each run. A wrongly chained sum damages every entry below the faulty index on that side. A fault that spends too many or too few cycles in compensation changes the count of idle request cycles.

// File: rtl/capcal_pkg.sv
package capcal_pkg;
    localparam int RES_BITS      = 14;
    localparam int MSB_CAPS      = 6;
    localparam int CAPS_PER_SIDE = MSB_CAPS + 2;
    localparam int CAP_W         = $clog2(CAPS_PER_SIDE);
    localparam int SIDES         = 2;
    localparam int ENTRIES       = SIDES * CAPS_PER_SIDE;
    localparam int ADDR_W        = $clog2(ENTRIES);
    localparam int VAL_W         = 16;
    localparam int CODE_W        = 16;
    localparam int SB_W          = 4;
    localparam int TOP_IDX       = MSB_CAPS - 1;
    localparam int UP_IDX        = MSB_CAPS;
    localparam int DOWN_IDX      = MSB_CAPS + 1;

    typedef logic signed [VAL_W-1:0] val_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CONV,
        ST_COMP
    } fsm_t;

    typedef struct packed {
        fsm_t             fsm;
        logic             side;
        logic [CAP_W-1:0] cap;
        logic             mode;
        logic [CAP_W-1:0] j;
        logic             done;
    } seq_t;
endpackage

// File: rtl/capcal_capmap.sv
module capcal_capmap
    import capcal_pkg::*;
(
    input  logic [CAP_W-1:0]  cap_i,
    output logic [CODE_W-1:0] ideal_o,
    output logic [SB_W-1:0]   start_bit_o
);
    always_comb begin
        if (int'(cap_i) >= TOP_IDX) begin
            ideal_o     = CODE_W'(1) << (RES_BITS - TOP_IDX);
            start_bit_o = SB_W'(MSB_CAPS + 1);
        end else begin
            ideal_o     = CODE_W'(1) << (RES_BITS - int'(cap_i));
            start_bit_o = SB_W'(int'(cap_i) + 2);
        end
    end
endmodule

// File: rtl/capcal_regfile.sv
module capcal_regfile
    import capcal_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              err_we_i,
    input  logic              off_we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  val_t              err_wdata_i,
    input  val_t              off_wdata_i,
    input  logic [ADDR_W:0]   rd_addr_i,
    output val_t              rd_data_o,
    output val_t              err_o [ENTRIES]
);
    val_t off_view [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        val_t e_q, e_d, o_q, o_d;

        always_comb begin
            e_d = e_q;
            o_d = o_q;
            if (err_we_i && waddr_i == ADDR_W'(g)) e_d = err_wdata_i;
            if (off_we_i && waddr_i == ADDR_W'(g)) o_d = off_wdata_i;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                e_q <= '0;
                o_q <= '0;
            end else begin
                e_q <= e_d;
                o_q <= o_d;
            end
        end

        assign err_o[g]    = e_q;
        assign off_view[g] = o_q;
    end

    always_comb begin
        if (rd_addr_i[ADDR_W]) rd_data_o = off_view[rd_addr_i[ADDR_W-1:0]];
        else                   rd_data_o = err_o[rd_addr_i[ADDR_W-1:0]];
    end

    AST_OFF_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
        off_we_i |-> err_we_i); // R8
endmodule

// File: rtl/capcal_ctrl.sv
module capcal_ctrl
    import capcal_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              cv_ack_i,
    input  logic [CODE_W-1:0] cv_code_i,
    input  logic [CODE_W-1:0] ideal_i,
    input  val_t              err_i [ENTRIES],
    output logic              cv_req_o,
    output logic              cv_side_o,
    output logic [CAP_W-1:0]  cv_cap_o,
    output logic              cv_mode_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_we_o,
    output logic              off_we_o,
    output logic [ADDR_W-1:0] waddr_o,
    output val_t              err_wdata_o,
    output val_t              off_wdata_o
);
    localparam logic [CAP_W-1:0] CAP_DOWN = CAP_W'(DOWN_IDX);
    localparam logic [CAP_W-1:0] CAP_UP   = CAP_W'(UP_IDX);
    localparam logic [CAP_W-1:0] CAP_TOP  = CAP_W'(TOP_IDX);
    localparam logic [CAP_W-1:0] J_FIRST  = CAP_W'(TOP_IDX - 1);

    seq_t s_q, s_d;

    logic [ADDR_W-1:0] cur_addr;
    logic [CAP_W-1:0]  ext_idx;
    logic [CODE_W:0]   diff_w;
    val_t              diff_v;
    val_t              base_v;

    assign cur_addr = {s_q.side, s_q.cap};
    assign ext_idx  = s_q.side ? CAP_UP : CAP_DOWN;
    assign diff_w   = {1'b0, cv_code_i} - {1'b0, ideal_i};
    assign diff_v   = VAL_W'(diff_w);

    always_comb begin
        if (s_q.j == J_FIRST)
            base_v = err_i[{s_q.side, CAP_TOP}] + err_i[{s_q.side, ext_idx}];
        else
            base_v = err_i[{s_q.side, s_q.j + CAP_W'(1)}];
    end

    always_comb begin
        s_d         = s_q;
        err_we_o    = 1'b0;
        off_we_o    = 1'b0;
        waddr_o     = cur_addr;
        err_wdata_o = '0;
        off_wdata_o = '0;
        unique case (s_q.fsm)
            ST_IDLE: begin
                if (start_i) begin
                    s_d.fsm  = ST_CONV;
                    s_d.side = 1'b0;
                    s_d.cap  = CAP_DOWN;
                    s_d.mode = 1'b0;
                    s_d.done = 1'b0;
                end
            end
            ST_CONV: begin
                if (cv_ack_i) begin
                    err_we_o = 1'b1;
                    if (!s_q.mode) begin
                        err_wdata_o = diff_v;
                        if (s_q.cap == '0) begin
                            s_d.fsm = ST_COMP;
                            s_d.j   = J_FIRST;
                        end else begin
                            s_d.cap = s_q.cap - CAP_W'(1);
                        end
                    end else begin
                        off_we_o    = 1'b1;
                        off_wdata_o = diff_v;
                        err_wdata_o = err_i[cur_addr] - diff_v;
                        if (s_q.cap != '0) begin
                            s_d.cap = s_q.cap - CAP_W'(1);
                        end else if (!s_q.side) begin
                            s_d.side = 1'b1;
                            s_d.cap  = CAP_DOWN;
                        end else begin
                            s_d.fsm  = ST_IDLE;
                            s_d.done = 1'b1;
                        end
                    end
                end
            end
            ST_COMP: begin
                waddr_o     = {s_q.side, s_q.j};
                err_we_o    = 1'b1;
                err_wdata_o = err_i[{s_q.side, s_q.j}] + base_v;
                if (s_q.j == '0) begin
                    s_d.fsm = ST_CONV;
                    s_d.cap = CAP_DOWN;
                    if (!s_q.side) begin
                        s_d.side = 1'b1;
                    end else begin
                        s_d.side = 1'b0;
                        s_d.mode = 1'b1;
                    end
                end else begin
                    s_d.j = s_q.j - CAP_W'(1);
                end
            end
            default: s_d.fsm = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{fsm: ST_IDLE, side: 1'b0, cap: '0, mode: 1'b0, j: '0, done: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign cv_req_o  = (s_q.fsm == ST_CONV);
    assign busy_o    = (s_q.fsm != ST_IDLE);
    assign done_o    = s_q.done;
    assign cv_side_o = s_q.side;
    assign cv_cap_o  = s_q.cap;
    assign cv_mode_o = s_q.mode;

    AST_FIELDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (cv_req_o && !cv_ack_i) |=> (cv_req_o && cv_cap_o == $past(cv_cap_o)
            && cv_side_o == $past(cv_side_o) && cv_mode_o == $past(cv_mode_o))); // R9
    AST_CAP_DESCENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (cv_req_o && cv_ack_i && cv_cap_o != '0) |=>
            (cv_req_o && cv_cap_o == CAP_W'($past(cv_cap_o) - CAP_W'(1)))); // R2
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!cv_req_o && !busy_o)); // R10
    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(cv_ack_i && cv_mode_o && cv_side_o && cv_cap_o == '0)); // R2
    AST_WRITE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        err_we_o |-> busy_o); // R1
endmodule

// File: rtl/capcal_seq.sv
module capcal_seq
    import capcal_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              cv_req_o,
    output logic              cv_side_o,
    output logic [CAP_W-1:0]  cv_cap_o,
    output logic              cv_mode_o,
    output logic [SB_W-1:0]   cv_start_bit_o,
    input  logic              cv_ack_i,
    input  logic [CODE_W-1:0] cv_code_i,
    input  logic [ADDR_W:0]   rd_addr_i,
    output logic [VAL_W-1:0]  rd_data_o
);
    logic [CODE_W-1:0] ideal_w;
    val_t              err_w [ENTRIES];
    logic              err_we_w, off_we_w;
    logic [ADDR_W-1:0] waddr_w;
    val_t              err_wdata_w, off_wdata_w, rd_w;

    capcal_capmap u_map (
        .cap_i       (cv_cap_o),
        .ideal_o     (ideal_w),
        .start_bit_o (cv_start_bit_o)
    );

    capcal_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .cv_ack_i    (cv_ack_i),
        .cv_code_i   (cv_code_i),
        .ideal_i     (ideal_w),
        .err_i       (err_w),
        .cv_req_o    (cv_req_o),
        .cv_side_o   (cv_side_o),
        .cv_cap_o    (cv_cap_o),
        .cv_mode_o   (cv_mode_o),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .err_we_o    (err_we_w),
        .off_we_o    (off_we_w),
        .waddr_o     (waddr_w),
        .err_wdata_o (err_wdata_w),
        .off_wdata_o (off_wdata_w)
    );

    capcal_regfile u_rf (
        .clk         (clk),
        .rst_n       (rst_n),
        .err_we_i    (err_we_w),
        .off_we_i    (off_we_w),
        .waddr_i     (waddr_w),
        .err_wdata_i (err_wdata_w),
        .off_wdata_i (off_wdata_w),
        .rd_addr_i   (rd_addr_i),
        .rd_data_o   (rd_w),
        .err_o       (err_w)
    );

    assign rd_data_o = rd_w;

    AST_START_BIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cv_req_o |-> (cv_start_bit_o >= SB_W'(2) && cv_start_bit_o <= SB_W'(MSB_CAPS + 1))); // R3
    AST_WRITE_ONLY_ON_ACK_OR_COMP: assert property (@(posedge clk) disable iff (!rst_n)
        (off_we_w) |-> (cv_ack_i && cv_mode_o)); // R8
endmodule

// File: tb/capcal_seq_tb.sv
module capcal_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        busy_o, done_o, cv_req_o, cv_side_o, cv_mode_o;
    logic [2:0]  cv_cap_o;
    logic [3:0]  cv_start_bit_o;
    logic        cv_ack_i = 1'b0;
    logic [15:0] cv_code_i = '0;
    logic [4:0]  rd_addr_i = '0;
    logic [15:0] rd_data_o;

    always #2.5 clk = ~clk;

    capcal_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o), .done_o(done_o),
        .cv_req_o(cv_req_o), .cv_side_o(cv_side_o), .cv_cap_o(cv_cap_o),
        .cv_mode_o(cv_mode_o), .cv_start_bit_o(cv_start_bit_o), .cv_ack_i(cv_ack_i),
        .cv_code_i(cv_code_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o)
    );

    typedef struct { int side; int cap; int mode; int sb; } item_t;
    item_t exp_q[$];

    int n_vec = 0;
    int n_bad = 0;
    int mis [2][8];
    int off [2][8];
    int lat = 1;
    int eng_cnt = 0;
    int cur_side = 0, cur_cap = 0, cur_mode = 0;
    int gaps = 0;

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    function automatic int ideal_of(input int c);
        return (c >= 5) ? 512 : (1 << (14 - c));
    endfunction

    // driver side of the scoreboard: the request order that R2 and R3 define
    task automatic push_run();
        for (int m = 0; m < 2; m++)
            for (int s = 0; s < 2; s++)
                for (int c = 7; c >= 0; c--) begin
                    item_t it;
                    it.side = s; it.cap = c; it.mode = m;
                    it.sb = (c >= 5) ? 7 : c + 2;
                    exp_q.push_back(it);
                end
    endtask

    // conversion engine model and request monitor
    always @(negedge clk) begin
        if (cv_ack_i) begin
            cv_ack_i = 1'b0;
        end else if (eng_cnt > 0) begin
            eng_cnt--;
            if (eng_cnt == 0) begin
                cv_code_i = 16'(ideal_of(cur_cap) + off[cur_side][cur_cap]
                               + (cur_mode == 0 ? mis[cur_side][cur_cap] : 0));
                cv_ack_i = 1'b1;
            end
        end else if (cv_req_o) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R2 unexpected request", int'(cv_cap_o), -1);
            end else begin
                item_t it;
                it = exp_q.pop_front();
                chk(int'(cv_side_o) == it.side, "R2 side", int'(cv_side_o), it.side);
                chk(int'(cv_cap_o) == it.cap, "R2 capacitor", int'(cv_cap_o), it.cap);
                chk(int'(cv_mode_o) == it.mode, "R2 mode", int'(cv_mode_o), it.mode);
                chk(int'(cv_start_bit_o) == it.sb, "R3 start bit", int'(cv_start_bit_o), it.sb);
            end
            cur_side = int'(cv_side_o);
            cur_cap  = int'(cv_cap_o);
            cur_mode = int'(cv_mode_o);
            eng_cnt  = lat;
        end
    end

    always @(negedge clk) begin
        if (busy_o && !cv_req_o) gaps++;
    end

    task automatic rd(input int a, output int v);
        rd_addr_i = 5'(a);
        #1;
        v = int'($signed(rd_data_o));
    endtask

    // expected entries from R4..R8
    task automatic check_entries(input string tag);
        for (int s = 0; s < 2; s++) begin
            int raw [8];
            int comp [8];
            int ext;
            ext = (s == 1) ? 6 : 7;
            for (int i = 0; i < 8; i++) raw[i] = mis[s][i] + off[s][i];
            for (int i = 5; i < 8; i++) comp[i] = raw[i];
            comp[4] = raw[4] + raw[5] + raw[ext];
            for (int i = 3; i >= 0; i--) comp[i] = raw[i] + comp[i + 1];
            for (int i = 0; i < 8; i++) begin
                int v;
                rd(s * 8 + i, v);
                if (i >= 5)      chk(v == comp[i] - off[s][i], {tag, " R5 b6-level error"}, v, comp[i] - off[s][i]);
                else if (s == 0) chk(v == comp[i] - off[s][i], {tag, " R6 P compensated error"}, v, comp[i] - off[s][i]);
                else             chk(v == comp[i] - off[s][i], {tag, " R7 N compensated error"}, v, comp[i] - off[s][i]);
                rd(16 + s * 8 + i, v);
                chk(v == off[s][i], {tag, " R8 offset entry (R14 address)"}, v, off[s][i]);
            end
        end
    endtask

    task automatic run_cal(input string tag, input int l, input bit poke_start);
        int waited;
        lat = l;
        gaps = 0;
        push_run();
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        chk(done_o == 1'b0, {tag, " R11 done cleared by start"}, int'(done_o), 0);
        chk(busy_o == 1'b1, {tag, " R10 busy after start"}, int'(busy_o), 1);
        waited = 0;
        while (!done_o && waited < 20000) begin
            @(negedge clk);
            waited++;
            if (poke_start && waited == 37) start_i = 1'b1;   // R10 start while busy
            if (poke_start && waited == 38) start_i = 1'b0;
        end
        chk(done_o == 1'b1, {tag, " R10 done reached"}, int'(done_o), 1);
        chk(busy_o == 1'b0, {tag, " R10 busy low at done"}, int'(busy_o), 0);
        chk(exp_q.size() == 0, {tag, " R2 all requests seen"}, exp_q.size(), 0);
        chk(gaps == 10, {tag, " R13 idle request cycles"}, gaps, 10);
        check_entries(tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        int v;
        for (int s = 0; s < 2; s++)
            for (int i = 0; i < 8; i++) begin
                mis[s][i] = (s == 0 ? 1 : -1) * (3 * i + 1) - 5 + i * i;
                off[s][i] = i - 3 + 2 * s;
            end
        repeat (4) @(negedge clk);
        chk(done_o == 1'b0, "R1 done at reset", int'(done_o), 0);
        chk(busy_o == 1'b0, "R1 busy at reset", int'(busy_o), 0);
        chk(cv_req_o == 1'b0, "R1 request at reset", int'(cv_req_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int a = 0; a < 32; a++) begin
            rd(a, v);
            chk(v == 0, "R1 entry zero after reset", v, 0);
        end

        run_cal("A", 1, 1'b1);

        // R12: extreme measurements, slower engine; R11: restart overwrites
        for (int i = 0; i < 8; i++) begin
            mis[0][i] = (i >= 5) ? 522 : -522;
            mis[1][i] = (i >= 5) ? -500 : 522;
            off[0][i] = 3 - i;
            off[1][i] = -2 + (i % 3);
        end
        run_cal("B", 3, 1'b0);

        for (int s = 0; s < 2; s++)
            for (int i = 0; i < 8; i++) begin
                mis[s][i] = 7 * i - 20 + s * 11;
                off[s][i] = (i % 2 == 0) ? 1 : -1;
            end
        run_cal("C", 2, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule